// File: doc/BRIEF.md
# Window-ID Pixel Format Selector

This stage sits on the scanout path between the frame buffer and the color lookup. Every pixel arrives as one 32-bit word: 24 color bits, a 4-bit overlay field and a 4-bit window identifier. The identifier selects one of sixteen window modes from a small table. That mode tells the stage three things: whether the color bits hold a direct RGB value or a palette index, whether the color planes are split into two 12-bit buffers, and which of those buffers is shown. Each window can therefore keep its own format and flip buffers without tearing, independently of its neighbours.

A nonzero overlay field takes priority over the window mode. It sends out a palette index from a reserved overlay range, which is how pop-up menus and overlays are drawn on top of any window. Each result carries a tag that says whether the data is an RGB value, a window palette index or an overlay palette index. Software loads the mode table through a simple address/data write port. The stage has a fixed pipeline latency of two clocks, and a valid flag travels with each pixel.

Top module: `wid_fmt_sel`

## Requirements
- R1: A pixel presented with `in_valid` high appears at the outputs exactly two rising edges later with `out_valid` high. `out_valid` is low two edges after a cycle with `in_valid` low, and it is low after reset.
- R2: When `in_ovl` is nonzero, the output is tag 2 (overlay), with `out_data` = 12'hFF0 + `in_ovl`, zero-extended to 24 bits. The window mode has no effect on this.
- R3: In a mode entry, bit 0 selects RGB, bit 1 enables double buffering and bit 2 selects the shown buffer (0 = color bits 11:0, 1 = color bits 23:12). In RGB single-buffer mode the output is tag 1 and the 24 color bits unchanged.
- R4: In index single-buffer mode the output is tag 0 and color bits 11:0, zero-extended to 24 bits.
- R5: In index double-buffer mode the output is tag 0 and the shown 12-bit half, zero-extended to 24 bits.
- R6: In RGB double-buffer mode the shown half is read as three 4-bit channels, red in its top nibble. Each channel is widened to 8 bits by repeating the nibble, and the output is tag 1.
- R7: A write with `cfg_we` high stores `cfg_wdata` into entry `cfg_addr`. A pixel presented in the same cycle as the write still uses the old entry, and a pixel presented in the next cycle uses the new one.
- R8: While `out_valid` is low, `out_tag` and `out_data` are zero.
- R9: The buffer-select bit is ignored when double buffering is off: such an entry produces the same output as the same entry with the select bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode table write strobe |
| cfg_addr | input | 4 | Mode table entry to write |
| cfg_wdata | input | 3 | Mode entry {select, double, rgb} |
| in_valid | input | 1 | Pixel valid |
| in_wid | input | 4 | Window identifier of the pixel |
| in_ovl | input | 4 | Overlay field of the pixel |
| in_color | input | 24 | Color bits of the pixel |
| out_valid | output | 1 | Output valid, two clocks after input |
| out_tag | output | 2 | 0 = window index, 1 = RGB, 2 = overlay index |
| out_data | output | 24 | Palette index (zero-extended) or RGB value |

## Verification
The bench uses one color word whose two halves differ, so a design that shows the wrong buffer or ignores the select bit produces a visibly different index or RGB value. It puts an overlay pixel on an RGB window and on a double-buffered index window, where a wrong priority would leak the color bits through. It writes a table entry in the same cycle as a pixel using that entry, then sends another pixel one cycle later. A table with a write-first read, or one that updates late, would decode one of the two pixels in the wrong format. It also checks the valid timing one edge early and at the right edge, to catch a one- or three-stage pipeline, and it checks that an idle output is all zero.

// File: rtl/wid_fmt_pkg.sv
package wid_fmt_pkg;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic sel;  // shown buffer: 0 low half, 1 high half
    logic dbl;  // double buffered
    logic rgb;  // direct color
  } wmode_t;

  typedef enum logic [1:0] {
    TAG_IDX = 2'd0,
    TAG_RGB = 2'd1,
    TAG_OVL = 2'd2
  } tag_t;
endpackage

// File: rtl/wid_mode_table.sv
module wid_mode_table #(
  parameter int AW = 4,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port and registered read port; read returns the old entry on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wid_pix_decode.sv
module wid_pix_decode
  import wid_fmt_pkg::*;
#(
  parameter int COLOR_W = 24,
  parameter int OVL_W = 4,
  parameter int IDX_W = COLOR_W / 2,
  parameter logic [IDX_W-1:0] OVL_BASE = '1
) (
  input  wmode_t             mode,
  input  logic [OVL_W-1:0]   ovl,
  input  logic [COLOR_W-1:0] color,
  output logic [1:0]         tag,
  output logic [COLOR_W-1:0] data
);
  localparam int HALF_W = COLOR_W / 2;
  localparam int CH_W = HALF_W / 3;
  localparam int OCH_W = COLOR_W / 3;

  logic [HALF_W-1:0]  half;
  logic [COLOR_W-1:0] expanded;
  logic [IDX_W-1:0]   ovl_idx;

  always_comb begin
    if (mode.dbl && mode.sel) half = color[COLOR_W-1:HALF_W];
    else                      half = color[HALF_W-1:0];
  end

  // widen each short channel by repeating it
  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign expanded[c*OCH_W +: OCH_W] = {half[c*CH_W +: CH_W], half[c*CH_W +: CH_W]};
  end

  assign ovl_idx = OVL_BASE + IDX_W'(ovl);

  always_comb begin
    if (ovl != '0) begin
      tag  = TAG_OVL;
      data = COLOR_W'(ovl_idx);
    end else if (mode.rgb) begin
      tag  = TAG_RGB;
      data = mode.dbl ? expanded : color;
    end else begin
      tag  = TAG_IDX;
      data = COLOR_W'(half);
    end
  end
endmodule

// File: rtl/wid_fmt_sel.sv
module wid_fmt_sel
  import wid_fmt_pkg::*;
#(
  parameter int COLOR_W = 24,
  parameter int WID_W = 4,
  parameter int OVL_W = 4,
  parameter int IDX_W = COLOR_W / 2,
  parameter logic [IDX_W-1:0] OVL_BASE = 12'hFF0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [WID_W-1:0]   cfg_addr,
  input  logic [MODE_W-1:0]  cfg_wdata,
  input  logic               in_valid,
  input  logic [WID_W-1:0]   in_wid,
  input  logic [OVL_W-1:0]   in_ovl,
  input  logic [COLOR_W-1:0] in_color,
  output logic               out_valid,
  output logic [1:0]         out_tag,
  output logic [COLOR_W-1:0] out_data
);
  // stage 1: table lookup alongside registered pixel fields
  logic [MODE_W-1:0]  mode_raw;
  logic               v1;
  logic [OVL_W-1:0]   ovl1;
  logic [COLOR_W-1:0] col1;
  logic [1:0]         dec_tag;
  logic [COLOR_W-1:0] dec_data;

  wid_mode_table #(.AW(WID_W), .DW(MODE_W)) u_tbl (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (in_wid),
    .rdata (mode_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    ovl1 <= in_ovl;
    col1 <= in_color;
  end

  wid_pix_decode #(
    .COLOR_W (COLOR_W),
    .OVL_W   (OVL_W),
    .IDX_W   (IDX_W),
    .OVL_BASE(OVL_BASE)
  ) u_dec (
    .mode  (wmode_t'(mode_raw)),
    .ovl   (ovl1),
    .color (col1),
    .tag   (dec_tag),
    .data  (dec_data)
  );

  // stage 2: registered outputs, zeroed when idle
  always_ff @(posedge clk) begin
    if (rst || !v1) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b1;
      out_tag   <= dec_tag;
      out_data  <= dec_data;
    end
  end
endmodule

// File: rtl/wid_fmt_sel_chk.sv
module wid_fmt_sel_chk #(
  parameter int COLOR_W = 24,
  parameter int OVL_W = 4,
  parameter int IDX_W = 12,
  parameter logic [IDX_W-1:0] OVL_BASE = 12'hFF0
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [OVL_W-1:0]   in_ovl,
  input logic               out_valid,
  input logic [1:0]         out_tag,
  input logic [COLOR_W-1:0] out_data
);
  // R1
  lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R1
  lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R2
  ovl_pri_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ovl != '0) |-> ##2
      (out_tag == 2'd2 && out_data[IDX_W-1:0] == OVL_BASE + IDX_W'($past(in_ovl, 2))
       && out_data[COLOR_W-1:IDX_W] == '0));

  // R2
  ovl_none_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ovl == '0) |-> ##2 (out_tag != 2'd2));

  // R4
  idx_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == 2'd0) |-> (out_data[COLOR_W-1:IDX_W] == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_tag == 2'd0 && out_data == '0));
endmodule

bind wid_fmt_sel wid_fmt_sel_chk #(
  .COLOR_W (COLOR_W),
  .OVL_W   (OVL_W),
  .IDX_W   (IDX_W),
  .OVL_BASE(OVL_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ovl    (in_ovl),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_data  (out_data)
);

// File: tb/sim_wid_fmt_sel.sv
module sim_wid_fmt_sel;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [2:0]  cfg_wdata;
  logic        in_valid;
  logic [3:0]  in_wid;
  logic [3:0]  in_ovl;
  logic [23:0] in_color;
  logic        out_valid;
  logic [1:0]  out_tag;
  logic [23:0] out_data;

  int checks = 0;
  int errors = 0;

  // {wid, ovl, color, expected tag, expected data}
  localparam logic [57:0] VEC [NV] = '{
    {4'd0,  4'd0, 24'hABC123, 2'd0, 24'h000123},  // R4 index single
    {4'd1,  4'd0, 24'hABC123, 2'd1, 24'hABC123},  // R3 rgb single
    {4'd2,  4'd0, 24'hABC123, 2'd0, 24'h000123},  // R5 index dbl low
    {4'd3,  4'd0, 24'hABC123, 2'd0, 24'h000ABC},  // R5 index dbl high
    {4'd4,  4'd0, 24'hABC123, 2'd1, 24'h112233},  // R6 rgb dbl low
    {4'd5,  4'd0, 24'hABC123, 2'd1, 24'hAABBCC},  // R6 rgb dbl high
    {4'd6,  4'd0, 24'hABC123, 2'd0, 24'h000123},  // R9 sel ignored, index
    {4'd7,  4'd0, 24'hABC123, 2'd1, 24'hABC123},  // R9 sel ignored, rgb
    {4'd1,  4'd5, 24'hABC123, 2'd2, 24'h000FF5},  // R2 overlay on rgb
    {4'd3,  4'hF, 24'hABC123, 2'd2, 24'h000FFF},  // R2 overlay on dbl index
    {4'd15, 4'd0, 24'h00FF10, 2'd1, 24'h00FF10},  // R3 last entry
    {4'd2,  4'd0, 24'hFFFFFF, 2'd0, 24'h000FFF}   // R5 all ones
  };

  wid_fmt_sel u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_wid(in_wid),
    .in_ovl(in_ovl), .in_color(in_color), .out_valid(out_valid),
    .out_tag(out_tag), .out_data(out_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic v, input logic [1:0] t,
                       input logic [23:0] d);
    checks++;
    if (out_valid !== v || out_tag !== t || out_data !== d) begin
      errors++;
      $display("FAIL %s: got valid=%0b tag=%0d data=%06h, expected valid=%0b tag=%0d data=%06h",
               req, out_valid, out_tag, out_data, v, t, d);
    end
  endtask

  task automatic wr_mode(input logic [3:0] a, input logic [2:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_wid = '0; in_ovl = '0; in_color = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 R1 reset state
    check("R1 reset", 1'b0, 2'd0, 24'h0);

    // mode bits: [0] rgb, [1] dbl, [2] sel   (R3)
    wr_mode(4'd0, 3'b000);
    wr_mode(4'd1, 3'b001);
    wr_mode(4'd2, 3'b010);
    wr_mode(4'd3, 3'b110);
    wr_mode(4'd4, 3'b011);
    wr_mode(4'd5, 3'b111);
    wr_mode(4'd6, 3'b100);
    wr_mode(4'd7, 3'b101);
    wr_mode(4'd8, 3'b000);
    wr_mode(4'd15, 3'b001);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_wid = VEC[i][57:54]; in_ovl = VEC[i][53:50]; in_color = VEC[i][49:26];
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check($sformatf("vector %0d", i), 1'b1, VEC[i][25:24], VEC[i][23:0]);
    end

    // R1 latency: nothing after one edge, result after two
    @(negedge clk);
    in_valid = 1'b1; in_wid = 4'd1; in_ovl = 4'd0; in_color = 24'h123456;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 one edge", 1'b0, 2'd0, 24'h0);
    @(negedge clk);
    check("R1 two edges", 1'b1, 2'd1, 24'h123456);
    @(negedge clk);
    check("R8 idle", 1'b0, 2'd0, 24'h0);

    // R7 write collision: same-cycle pixel sees old entry, next sees new
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 3'b001;
    in_valid = 1'b1; in_wid = 4'd8; in_ovl = 4'd0; in_color = 24'hABC123;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 old entry", 1'b1, 2'd0, 24'h000123);
    @(negedge clk);
    check("R7 new entry", 1'b1, 2'd1, 24'hABC123);
    @(negedge clk);
    check("R8 idle after burst", 1'b0, 2'd0, 24'h0);

    // R2 overlay overrides a freshly rewritten double-buffer rgb entry
    wr_mode(4'd8, 3'b111);
    @(negedge clk);
    in_valid = 1'b1; in_wid = 4'd8; in_ovl = 4'd1; in_color = 24'hFFFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 overlay min", 1'b1, 2'd2, 24'h000FF1);

    // R1 valid cleared by reset mid-flight
    @(negedge clk);
    in_valid = 1'b1; in_ovl = 4'd0;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset flush", 1'b0, 2'd0, 24'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule